// File: doc/BRIEF.md
# Operand Input Pipeline with Pre-Adder

This block is the operand front end of an arithmetic slice. A 30-bit A operand arrives either on a direct port or on a chain input from the neighbouring slice. It passes through zero, one or two register stages. A copy of the A value is tapped at a chosen depth and sent on down the chain. A 25-bit D operand is registered, and a pre-adder combines D with the low 25 bits of one of the A registers. The sum is optionally registered and becomes the operand for a downstream multiplier.

Four mode bits, applied every cycle, control the pre-adder:
- which A register it reads;
- whether the A contribution is forced to zero;
- whether the D contribution is forced to zero;
- whether A is added to D or taken away from it.

Every register has its own clock enable. A single synchronous reset covers the A registers, and a second one covers the D and sum registers.

Structural choices are fixed at elaboration. These are the A depth, the chain tap depth, the A source and whether the sum register is present. Illegal depth pairs stop elaboration.

Top module: `opnd_prepipe`

## Requirements
- R1: With `A_FROM_CASC`=0 the A path loads `a_in`; with `A_FROM_CASC`=1 it loads `acasc_in` instead.
- R2: With both A enables held high, `a_pipe_out` equals the selected A source delayed by `A_DEPTH` cycles (0, 1 or 2).
- R3: `acasc_out` carries the A source after `CASC_DEPTH` stages. The legal pairs (A_DEPTH, CASC_DEPTH) are (0,0), (1,1), (2,1) and (2,2); any other pair stops elaboration.
- R4: The first and second A registers hold their value in any cycle where `ce_a1` or `ce_a2` respectively is low, independently of each other.
- R5: `rst_a` high at a clock edge clears both A registers whatever their enables, and leaves the D and sum registers unchanged.
- R6: `rst_d` high at a clock edge clears the D and sum registers whatever their enables, and leaves the A registers unchanged.
- R7: The D register holds while `ce_d` is low; the sum register holds while `ce_ad` is low.
- R8: `mode[0]`=1 feeds the pre-adder from the first A register and `mode[0]`=0 from the last A register. With `A_DEPTH`=1 the "first" value is the unregistered A source; with depth 0 both are the source.
- R9: `mode[1]`=1 replaces the A contribution by zero; `mode[2]`=1 replaces the registered D by zero; with both set the pre-adder result is zero.
- R10: The pre-adder computes D+A when `mode[3]`=0 and D−A when `mode[3]`=1. Only bits 24:0 of the selected A value are used, and the result wraps modulo 2^25.
- R11: With `AD_REG`=1, `pa_out` is the pre-adder result captured at the previous enabled edge. With `AD_REG`=0 it follows the pre-adder combinationally, in the same cycle as the mode bits.
- R12: `a_pipe_out` presents the full 30 bits of the last A stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_a | input | 1 | Synchronous clear of the A registers |
| rst_d | input | 1 | Synchronous clear of the D and sum registers |
| ce_a1 | input | 1 | Enable of the first A register |
| ce_a2 | input | 1 | Enable of the last A register |
| ce_d | input | 1 | Enable of the D register |
| ce_ad | input | 1 | Enable of the sum register |
| a_in | input | 30 | Direct A operand |
| acasc_in | input | 30 | A operand from the neighbouring slice |
| d_in | input | 25 | D operand |
| mode | input | 4 | Pre-adder control: [0] first A, [1] zero A, [2] zero D, [3] subtract |
| a_pipe_out | output | 30 | A value after the full A pipeline |
| acasc_out | output | 30 | A value tapped for the next slice |
| pa_out | output | 25 | Pre-adder result toward the multiplier |

## Verification
Some properties are checked on every cycle:
- each disabled register keeps its value;
- the sum register captures exactly the previous pre-adder result when enabled;
- setting both zero-forcing mode bits gives a zero result.

Other behaviour is shown only by the bench's scenarios, run on two configurations side by side:
- the A source choice and the A pipeline depth;
- the chain tap depth;
- the split between the two reset groups;
- subtraction with modulo-2^25 wrap;
- A values whose upper five bits must be ignored.

// File: rtl/opnd_pkg.sv
package opnd_pkg;

    localparam int unsigned OPND_A_W = 30;
    localparam int unsigned OPND_D_W = 25;
    localparam int unsigned MODE_W   = 4;

    // mode bit positions
    localparam int unsigned MB_PICK_FIRST = 0;
    localparam int unsigned MB_KILL_A     = 1;
    localparam int unsigned MB_KILL_D     = 2;
    localparam int unsigned MB_NEGATE_A   = 3;

    function automatic bit depths_ok(input int unsigned a_depth, input int unsigned casc_depth);
        return (a_depth == 0 && casc_depth == 0) ||
               (a_depth == 1 && casc_depth == 1) ||
               (a_depth == 2 && (casc_depth == 1 || casc_depth == 2));
    endfunction

endpackage

// File: rtl/opnd_a_pipe.sv
module opnd_a_pipe #(
    parameter int unsigned A_W         = 30,
    parameter int unsigned PA_W        = 25,
    parameter int unsigned A_DEPTH     = 2,
    parameter int unsigned CASC_DEPTH  = 1,
    parameter bit          A_FROM_CASC = 1'b0
) (
    input  logic            clk,
    input  logic            rst_a,
    input  logic            ce_a1,
    input  logic            ce_a2,
    input  logic [A_W-1:0]  a_in,
    input  logic [A_W-1:0]  acasc_in,
    input  logic            pick_first,
    output logic [A_W-1:0]  a_last_o,
    output logic [A_W-1:0]  casc_o,
    output logic [PA_W-1:0] pre_a_o
);

    logic [A_W-1:0] src;

    always_comb begin
        src = A_FROM_CASC ? acasc_in : a_in;
    end

    generate
        if (A_DEPTH == 2) begin : g_two
            typedef struct packed {
                logic [A_W-1:0] a1;
                logic [A_W-1:0] a2;
            } pair_t;

            pair_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (rst_a) begin
                    st_d = '0;
                end else begin
                    if (ce_a1) st_d.a1 = src;
                    if (ce_a2) st_d.a2 = st_q.a1;
                end
            end

            always_ff @(posedge clk) begin
                st_q <= st_d;
            end

            assign a_last_o = st_q.a2;
            assign casc_o   = (CASC_DEPTH == 2) ? st_q.a2 : st_q.a1;
            assign pre_a_o  = pick_first ? st_q.a1[PA_W-1:0] : st_q.a2[PA_W-1:0];

            // R4
            a1_hold_chk: assert property (@(posedge clk) disable iff (rst_a)
                !ce_a1 |=> $stable(st_q.a1));

            // R4
            a2_hold_chk: assert property (@(posedge clk) disable iff (rst_a)
                !ce_a2 |=> $stable(a_last_o));
        end else if (A_DEPTH == 1) begin : g_one
            logic [A_W-1:0] a2_d, a2_q;

            always_comb begin
                a2_d = a2_q;
                if (rst_a)      a2_d = '0;
                else if (ce_a2) a2_d = src;
            end

            always_ff @(posedge clk) begin
                a2_q <= a2_d;
            end

            assign a_last_o = a2_q;
            assign casc_o   = a2_q;
            assign pre_a_o  = pick_first ? src[PA_W-1:0] : a2_q[PA_W-1:0];

            // R4
            a2_hold_chk: assert property (@(posedge clk) disable iff (rst_a)
                !ce_a2 |=> $stable(a_last_o));
        end else begin : g_zero
            assign a_last_o = src;
            assign casc_o   = src;
            assign pre_a_o  = src[PA_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/opnd_preadd.sv
module opnd_preadd #(
    parameter int unsigned W = 25
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] d_i,
    input  logic         kill_a,
    input  logic         kill_d,
    input  logic         negate_a,
    output logic [W-1:0] sum_o
);

    logic [W-1:0] a_op, d_op;

    always_comb begin
        a_op  = kill_a ? '0 : a_i;
        d_op  = kill_d ? '0 : d_i;
        sum_o = negate_a ? (d_op - a_op) : (d_op + a_op);
    end

endmodule

// File: rtl/opnd_prepipe.sv
module opnd_prepipe
    import opnd_pkg::*;
#(
    parameter int unsigned A_W         = OPND_A_W,
    parameter int unsigned D_W         = OPND_D_W,
    parameter int unsigned A_DEPTH     = 2,
    parameter int unsigned CASC_DEPTH  = 1,
    parameter bit          A_FROM_CASC = 1'b0,
    parameter bit          AD_REG      = 1'b1
) (
    input  logic              clk,
    input  logic              rst_a,
    input  logic              rst_d,
    input  logic              ce_a1,
    input  logic              ce_a2,
    input  logic              ce_d,
    input  logic              ce_ad,
    input  logic [A_W-1:0]    a_in,
    input  logic [A_W-1:0]    acasc_in,
    input  logic [D_W-1:0]    d_in,
    input  logic [MODE_W-1:0] mode,
    output logic [A_W-1:0]    a_pipe_out,
    output logic [A_W-1:0]    acasc_out,
    output logic [D_W-1:0]    pa_out
);

    localparam int unsigned PA_W = D_W;

    generate
        if (!depths_ok(A_DEPTH, CASC_DEPTH)) begin : g_bad_depths
            initial $fatal(1, "opnd_prepipe: unsupported A_DEPTH/CASC_DEPTH pair");
        end
    endgenerate

    logic [PA_W-1:0] pre_a;
    logic [PA_W-1:0] pa_sum;

    opnd_a_pipe #(
        .A_W         (A_W),
        .PA_W        (PA_W),
        .A_DEPTH     (A_DEPTH),
        .CASC_DEPTH  (CASC_DEPTH),
        .A_FROM_CASC (A_FROM_CASC)
    ) u_a_pipe (
        .clk        (clk),
        .rst_a      (rst_a),
        .ce_a1      (ce_a1),
        .ce_a2      (ce_a2),
        .a_in       (a_in),
        .acasc_in   (acasc_in),
        .pick_first (mode[MB_PICK_FIRST]),
        .a_last_o   (a_pipe_out),
        .casc_o     (acasc_out),
        .pre_a_o    (pre_a)
    );

    // D operand register
    logic [D_W-1:0] dreg_d, dreg_q;

    always_comb begin
        dreg_d = dreg_q;
        if (rst_d)     dreg_d = '0;
        else if (ce_d) dreg_d = d_in;
    end

    always_ff @(posedge clk) begin
        dreg_q <= dreg_d;
    end

    // R7
    d_hold_chk: assert property (@(posedge clk) disable iff (rst_d)
        !ce_d |=> $stable(dreg_q));

    opnd_preadd #(
        .W (PA_W)
    ) u_preadd (
        .a_i      (pre_a),
        .d_i      (dreg_q),
        .kill_a   (mode[MB_KILL_A]),
        .kill_d   (mode[MB_KILL_D]),
        .negate_a (mode[MB_NEGATE_A]),
        .sum_o    (pa_sum)
    );

    // R9
    zero_both_chk: assert property (@(posedge clk) disable iff (rst_d)
        (mode[MB_KILL_A] && mode[MB_KILL_D]) |-> (pa_sum == '0));

    generate
        if (AD_REG) begin : g_ad_reg
            logic [PA_W-1:0] ad_d, ad_q;

            always_comb begin
                ad_d = ad_q;
                if (rst_d)      ad_d = '0;
                else if (ce_ad) ad_d = pa_sum;
            end

            always_ff @(posedge clk) begin
                ad_q <= ad_d;
            end

            assign pa_out = ad_q;

            // R7
            ad_hold_chk: assert property (@(posedge clk) disable iff (rst_d)
                !ce_ad |=> $stable(pa_out));

            // R11
            ad_capture_chk: assert property (@(posedge clk) disable iff (rst_d)
                ce_ad |=> (pa_out == $past(pa_sum)));
        end else begin : g_ad_bypass
            assign pa_out = pa_sum;
        end
    endgenerate

endmodule

// File: tb/test_opnd_prepipe.sv
module test_opnd_prepipe;

    logic        clk = 1'b0;
    logic        rst_a, rst_d, ce_a1, ce_a2, ce_d, ce_ad;
    logic [29:0] a_in, acasc_in;
    logic [24:0] d_in;
    logic [3:0]  mode;
    logic [29:0] p0_a, p0_c, p1_a, p1_c;
    logic [24:0] p0_pa, p1_pa;

    int compared   = 0;
    int mismatched = 0;
    bit done       = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    // default build: direct A, two stages, tap after one, registered sum
    opnd_prepipe i_opnd_prepipe (
        .clk(clk), .rst_a(rst_a), .rst_d(rst_d), .ce_a1(ce_a1), .ce_a2(ce_a2),
        .ce_d(ce_d), .ce_ad(ce_ad), .a_in(a_in), .acasc_in(acasc_in), .d_in(d_in),
        .mode(mode), .a_pipe_out(p0_a), .acasc_out(p0_c), .pa_out(p0_pa)
    );

    // second build: chain A, one stage, tap after one, combinational sum
    opnd_prepipe #(
        .A_DEPTH(1), .CASC_DEPTH(1), .A_FROM_CASC(1'b1), .AD_REG(1'b0)
    ) i_opnd_prepipe_alt (
        .clk(clk), .rst_a(rst_a), .rst_d(rst_d), .ce_a1(ce_a1), .ce_a2(ce_a2),
        .ce_d(ce_d), .ce_ad(ce_ad), .a_in(a_in), .acasc_in(acasc_in), .d_in(d_in),
        .mode(mode), .a_pipe_out(p1_a), .acasc_out(p1_c), .pa_out(p1_pa)
    );

    typedef struct {
        string       tag;
        logic [29:0] a0, c0, a1, c1;
        logic [24:0] pa0, pa1;
    } exp_t;

    exp_t sb_q[$];

    // reference state
    logic [29:0] m_a1 = '0, m_a2 = '0, n_a2 = '0;
    logic [24:0] m_d = '0, m_ad = '0, n_d = '0;

    function automatic logic [24:0] ref_pa(input logic [3:0] md, input logic [29:0] a,
                                           input logic [24:0] d);
        logic [24:0] aa, dd;
        aa = md[1] ? 25'd0 : a[24:0];
        dd = md[2] ? 25'd0 : d;
        return md[3] ? (dd - aa) : (dd + aa);
    endfunction

    function automatic logic [29:0] rnd30();
        logic [31:0] r;
        r = $urandom();
        return r[29:0];
    endfunction

    function automatic logic [24:0] rnd25();
        logic [31:0] r;
        r = $urandom();
        return r[24:0];
    endfunction

    task automatic step(input string tag, input logic ra, input logic rd,
                        input logic c1, input logic c2, input logic cd, input logic cad,
                        input logic [29:0] ai, input logic [29:0] ac,
                        input logic [24:0] di, input logic [3:0] md);
        exp_t        e;
        logic [24:0] pre;
        @(negedge clk);
        rst_a = ra; rst_d = rd; ce_a1 = c1; ce_a2 = c2; ce_d = cd; ce_ad = cad;
        a_in = ai; acasc_in = ac; d_in = di; mode = md;
        // default build, sum captured from pre-edge state
        pre = ref_pa(md, md[0] ? m_a1 : m_a2, m_d);
        if (ra) begin
            m_a1 = '0; m_a2 = '0;
        end else begin
            if (c2) m_a2 = m_a1;
            if (c1) m_a1 = ai;
        end
        if (rd) begin
            m_d = '0; m_ad = '0;
        end else begin
            if (cad) m_ad = pre;
            if (cd)  m_d  = di;
        end
        // second build
        if (ra)      n_a2 = '0;
        else if (c2) n_a2 = ac;
        if (rd)      n_d = '0;
        else if (cd) n_d = di;
        e.tag = tag;
        e.a0  = m_a2;  e.c0 = m_a1;  e.pa0 = m_ad;
        e.a1  = n_a2;  e.c1 = n_a2;
        e.pa1 = ref_pa(md, md[0] ? ac : n_a2, n_d);
        sb_q.push_back(e);
    endtask

    task automatic chk(input string tag, input string what,
                       input logic [29:0] act, input logic [29:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                chk(e.tag, "a_pipe_out(default)", p0_a, e.a0);
                chk(e.tag, "acasc_out(default)",  p0_c, e.c0);
                chk(e.tag, "pa_out(default)",     {5'd0, p0_pa}, {5'd0, e.pa0});
                chk(e.tag, "a_pipe_out(alt)",     p1_a, e.a1);
                chk(e.tag, "acasc_out(alt)",      p1_c, e.c1);
                chk(e.tag, "pa_out(alt)",         {5'd0, p1_pa}, {5'd0, e.pa1});
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            report();
            $finish;
        end
    end

    // stimulus
    initial begin
        rst_a = 1'b1; rst_d = 1'b1; ce_a1 = 1'b0; ce_a2 = 1'b0; ce_d = 1'b0; ce_ad = 1'b0;
        a_in = '0; acasc_in = '0; d_in = '0; mode = '0;

        // R5 R6 reset state
        repeat (2) step("R5/R6 reset", 1, 1, 1, 1, 1, 1, rnd30(), rnd30(), rnd25(), 4'b0000);

        // R1 R2 R3 R12 plain streaming, add, last A register
        for (int i = 0; i < 10; i++)
            step("R1/R2/R3/R12 stream", 0, 0, 1, 1, 1, 1, rnd30(), rnd30(), rnd25(), 4'b0000);

        // R8 first A register
        for (int i = 0; i < 6; i++)
            step("R8 pick first", 0, 0, 1, 1, 1, 1, rnd30(), rnd30(), rnd25(), 4'b0001);

        // R9 zero forcing
        for (int i = 0; i < 4; i++)
            step("R9 zero A", 0, 0, 1, 1, 1, 1, rnd30(), rnd30(), rnd25(), 4'b0010);
        for (int i = 0; i < 4; i++)
            step("R9 zero D", 0, 0, 1, 1, 1, 1, rnd30(), rnd30(), rnd25(), 4'b0100);
        for (int i = 0; i < 3; i++)
            step("R9 zero both", 0, 0, 1, 1, 1, 1, rnd30(), rnd30(), rnd25(), 4'b0110);

        // R10 subtraction
        for (int i = 0; i < 4; i++)
            step("R10 subtract", 0, 0, 1, 1, 1, 1, rnd30(), rnd30(), rnd25(), 4'b1000);
        for (int i = 0; i < 4; i++)
            step("R10 subtract first", 0, 0, 1, 1, 1, 1, rnd30(), rnd30(), rnd25(), 4'b1001);
        // R10 wrap below zero, upper A bits set and ignored
        for (int i = 0; i < 4; i++)
            step("R10 wrap sub", 0, 0, 1, 1, 1, 1, 30'h3E00_0001, 30'h3E00_0001, 25'd0, 4'b1000);
        // R10 wrap above 2^25
        for (int i = 0; i < 4; i++)
            step("R10 wrap add", 0, 0, 1, 1, 1, 1, 30'h3E00_0001, 30'h3E00_0001,
                 25'h1FF_FFFF, 4'b0000);

        // R4 first A register held, then last A register held
        for (int i = 0; i < 3; i++)
            step("R4 hold first", 0, 0, 0, 1, 1, 1, rnd30(), rnd30(), rnd25(), 4'b0001);
        for (int i = 0; i < 3; i++)
            step("R4 load", 0, 0, 1, 1, 1, 1, rnd30(), rnd30(), rnd25(), 4'b0000);
        for (int i = 0; i < 3; i++)
            step("R4 hold last", 0, 0, 1, 0, 1, 1, rnd30(), rnd30(), rnd25(), 4'b0000);

        // R7 D and sum registers held
        for (int i = 0; i < 3; i++)
            step("R7 hold D", 0, 0, 1, 1, 0, 1, rnd30(), rnd30(), rnd25(), 4'b0010);
        for (int i = 0; i < 3; i++)
            step("R7/R11 hold sum", 0, 0, 1, 1, 1, 0, rnd30(), rnd30(), rnd25(), 4'b0000);

        // R5 A reset alone, R6 D reset alone
        for (int i = 0; i < 3; i++)
            step("R5 load", 0, 0, 1, 1, 1, 1, rnd30(), rnd30(), rnd25(), 4'b0000);
        step("R5 A reset only", 1, 0, 0, 0, 0, 0, rnd30(), rnd30(), rnd25(), 4'b0000);
        step("R5 after", 0, 0, 0, 0, 0, 0, rnd30(), rnd30(), rnd25(), 4'b0100);
        for (int i = 0; i < 3; i++)
            step("R6 load", 0, 0, 1, 1, 1, 1, rnd30(), rnd30(), rnd25(), 4'b0000);
        step("R6 D reset only", 0, 1, 0, 0, 0, 0, rnd30(), rnd30(), rnd25(), 4'b0000);
        step("R6 after", 0, 0, 0, 0, 0, 0, rnd30(), rnd30(), rnd25(), 4'b0010);

        // R11 mixed traffic: random mode and enables
        for (int i = 0; i < 60; i++) begin
            logic [31:0] r;
            r = $urandom();
            step("R11 mix", (r[7:4] == 4'd0), (r[11:8] == 4'd0), r[12] | r[13], r[14] | r[15],
                 r[16] | r[17], r[18] | r[19], rnd30(), rnd30(), rnd25(), r[3:0]);
        end

        step("R2 drain", 0, 0, 1, 1, 1, 1, rnd30(), rnd30(), rnd25(), 4'b0000);
        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        report();
        $finish;
    end

endmodule